// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

A 32-bit integer arithmetic and logic unit for a simple RISC execute stage. Each accepted operation takes two operands, a 5-bit constant shift amount and a 4-bit operation code. It produces a 32-bit result and a single-cycle overflow trap strobe. The unit covers signed and unsigned add and subtract, signed and unsigned set-less-than, logical and arithmetic shifts by a constant or by a register-supplied amount, and bitwise AND, OR, NOR and XOR.

The trapping and non-trapping add and subtract forms share one adder. Subtraction feeds the inverted second operand and a carry-in of one. Overflow is found from the operand and result signs, and it is raised as a trap only for the signed forms. The result and the trap are registered, so they appear one clock after an operation is presented with `in_valid` high. The register file, decode, exception-PC handling, multiply, divide and floating point sit outside this block.

Top module: `int_alu_trap`

## Requirements
- R1: ADD (op 0), ADDU (op 1), SUB (op 2) and SUBU (op 3) return the 32-bit wrapped sum a+b or difference a-b. The difference is computed as a + ~b + 1.
- R2: ADD raises `ovf_trap` when both operands are non-negative and the sum is negative, or when both are negative and the sum is non-negative.
- R3: SUB raises `ovf_trap` when a non-negative minus a negative gives a negative result, or a negative minus a non-negative gives a non-negative result. Operands of equal sign never trap.
- R4: ADDU, SUBU and every other operation never raise `ovf_trap`, even when the bit pattern matches a signed overflow.
- R5: SLT (op 4) returns 1 when a < b as two's complement and 0 otherwise, with result bits 31..1 always zero. For a=0xFFFFFFFF and b=1 it returns 1.
- R6: SLTU (op 5) returns 1 when a < b as unsigned and 0 otherwise. For a=0xFFFFFFFF and b=1 it returns 0.
- R7: SLL (op 6) and SRL (op 7) shift b by `shamt`, fill the vacated bits with zeros and drop the bits shifted out.
- R8: SRA (op 8) shifts b right by `shamt` and copies bit 31 into the vacated bits.
- R9: SLLV (op 9), SRLV (op 10) and SRAV (op 11) shift b by a[4:0] and ignore the upper bits of a and the `shamt` input. The range is 0 to 31.
- R10: AND (op 12), OR (op 13), NOR (op 14) and XOR (op 15) act bit by bit on a and b.
- R11: `res_valid`, `result` and `ovf_trap` update on the clock edge after `in_valid` is sampled high. A signed overflow presented with `in_valid` low raises no trap. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| opa | input | 32 | First operand; low 5 bits are the variable shift amount |
| opb | input | 32 | Second operand; the value shifted by shift operations |
| shamt | input | 5 | Constant shift amount |
| res_valid | output | 1 | Result registered from a valid operation |
| result | output | 32 | Registered result |
| ovf_trap | output | 1 | One-cycle signed overflow trap strobe |

## Verification
Add and subtract are exercised at the sign boundaries: 0x7FFFFFFF+1, 0x80000000-1, sums of two negatives, and mixed-sign pairs. The same operands are run through the signed and unsigned forms, which separates the trap qualification from the shared adder. Set-less-than uses all-ones against one, so the signed and unsigned comparisons give opposite answers. Shifts use a negative operand at amounts 0, 1 and 31, and use variable amounts with upper bits set, which shows the difference between zero fill and sign fill and shows which amount source is used.

// File: rtl/alu_pkg.sv
// Shared operation codes for the integer ALU.
// Assumes a 4-bit operation select driven by the decode stage.
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_SLT  = 4'd4,
        OP_SLTU = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_SLLV = 4'd9,
        OP_SRLV = 4'd10,
        OP_SRAV = 4'd11,
        OP_AND  = 4'd12,
        OP_OR   = 4'd13,
        OP_NOR  = 4'd14,
        OP_XOR  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOR = 2'd2,
        LG_XOR = 2'd3
    } logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared adder for add, subtract and both compares.
// Subtract feeds ~b with carry-in 1. Reports the signed overflow,
// the signed less-than and the unsigned less-than of a against b.
// Assumes sub=1 whenever a compare result is consumed.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_s,
    output logic         lt_u
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    // Select b or its inverse and add with carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
    end

    // Sign-based overflow and the two compare flags.
    always_comb begin
        if (sub)
            ovf = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
        else
            ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        lt_s = sum[W-1] ^ ovf;
        lt_u = ~wide[W];
    end

    // Mixed-sign add and same-sign subtract never overflow.
    always_comb begin
        if (!sub && (a[W-1] != b[W-1]))
            AST_MIXED_ADD_SAFE: assert (!ovf); // R2
        if (sub && (a[W-1] == b[W-1]))
            AST_SAME_SUB_SAFE: assert (!ovf); // R3
    end
endmodule

// File: rtl/alu_shifter.sv
// Logarithmic barrel shifter. It shifts right with a zero or sign fill.
// A left shift reverses the bits, shifts right and reverses back.
// Assumes arith is only used with dir_left=0.
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           dir_left,
    input  logic           arith,
    output logic [W-1:0]   dout
);
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] src;
    logic         fill;
    logic [W-1:0] stage [SHW+1];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_rev
            assign rev_in[gi]  = din[W-1-gi];
            assign rev_out[gi] = stage[SHW][W-1-gi];
        end
    endgenerate

    // Pick the stage input and the fill bit.
    always_comb begin
        src  = dir_left ? rev_in : din;
        fill = arith & ~dir_left & din[W-1];
    end

    assign stage[0] = src;

    generate
        for (gi = 0; gi < SHW; gi++) begin : g_stage
            localparam int STEP = 1 << gi;
            assign stage[gi+1] = amt[gi] ? {{STEP{fill}}, stage[gi][W-1:STEP]}
                                         : stage[gi];
        end
    endgenerate

    // Restore the bit order for left shifts.
    always_comb begin
        dout = dir_left ? rev_out : stage[SHW];
    end

    // A zero amount passes the operand through unchanged.
    always_comb begin
        if (amt == '0)
            AST_ZERO_SHIFT_PASS: assert (dout == din); // R7
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise AND, OR, NOR and XOR unit.
// Assumes the function code comes from alu_pkg::logic_fn_e.
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    input  alu_pkg::logic_fn_e  fn,
    output logic [W-1:0]        y
);
    import alu_pkg::*;

    // Apply the selected bitwise function.
    always_comb begin
        case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_NOR:  y = ~(a | b);
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/int_alu_trap.sv
// Integer ALU top. It decodes the operation code and steers the operands
// to the shared adder, the shifter and the logic unit. It registers the
// result and raises a one-cycle trap on signed add or subtract overflow.
// Assumes: a variable shift takes its amount from opa[SHW-1:0], and
// every shift moves opb.
module int_alu_trap #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [3:0]     op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [SHW-1:0] shamt,
    output logic           res_valid,
    output logic [W-1:0]   result,
    output logic           ovf_trap
);
    import alu_pkg::*;

    alu_op_e        op_e;
    logic           do_sub;
    logic           trap_op;
    logic [W-1:0]   as_sum;
    logic           as_ovf;
    logic           as_lt_s;
    logic           as_lt_u;
    logic [SHW-1:0] sh_amt;
    logic           sh_left;
    logic           sh_arith;
    logic [W-1:0]   sh_out;
    logic_fn_e      lg_fn;
    logic [W-1:0]   lg_out;
    logic [W-1:0]   res_d;

    // Decode the operation into unit controls.
    always_comb begin
        op_e     = alu_op_e'(op);
        do_sub   = (op_e == OP_SUB) || (op_e == OP_SUBU) ||
                   (op_e == OP_SLT) || (op_e == OP_SLTU);
        trap_op  = (op_e == OP_ADD) || (op_e == OP_SUB);
        sh_amt   = ((op_e == OP_SLLV) || (op_e == OP_SRLV) || (op_e == OP_SRAV))
                   ? opa[SHW-1:0] : shamt;
        sh_left  = (op_e == OP_SLL) || (op_e == OP_SLLV);
        sh_arith = (op_e == OP_SRA) || (op_e == OP_SRAV);
        lg_fn    = logic_fn_e'(op[1:0]);
    end

    alu_addsub #(.W(W)) u_addsub (
        .a    (opa),
        .b    (opb),
        .sub  (do_sub),
        .sum  (as_sum),
        .ovf  (as_ovf),
        .lt_s (as_lt_s),
        .lt_u (as_lt_u)
    );

    alu_shifter #(.W(W), .SHW(SHW)) u_shift (
        .din      (opb),
        .amt      (sh_amt),
        .dir_left (sh_left),
        .arith    (sh_arith),
        .dout     (sh_out)
    );

    alu_logic #(.W(W)) u_logic (
        .a  (opa),
        .b  (opb),
        .fn (lg_fn),
        .y  (lg_out)
    );

    // Select the unit output for the current operation.
    always_comb begin
        case (op_e)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: res_d = as_sum;
            OP_SLT:  res_d = {{(W-1){1'b0}}, as_lt_s};
            OP_SLTU: res_d = {{(W-1){1'b0}}, as_lt_u};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV: res_d = sh_out;
            default: res_d = lg_out;
        endcase
    end

    // Output register: result, valid and the trap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            ovf_trap  <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid)
                result <= res_d;
            ovf_trap  <= in_valid && trap_op && as_ovf;
        end
    end

    AST_TRAP_SIGNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> ($past(op) == OP_ADD || $past(op) == OP_SUB)); // R4

    AST_TRAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> res_valid); // R11

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R11

    AST_SLT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SLT || op == OP_SLTU)) |=> (result[W-1:1] == '0)); // R5
endmodule

// File: tb/sim_int_alu_trap.sv
module sim_int_alu_trap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  shamt = '0;
    logic        res_valid;
    logic [31:0] result;
    logic        ovf_trap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] q_res [$];
    logic        q_trp [$];
    string       q_tag [$];

    always #10 clk = ~clk;

    int_alu_trap u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .shamt(shamt),
        .res_valid(res_valid), .result(result), .ovf_trap(ovf_trap)
    );

    // Reference model written from the requirements.
    function automatic void model(input logic [3:0] o, input logic [31:0] a,
                                  input logic [31:0] b, input logic [4:0] s,
                                  output logic [31:0] r, output logic t);
        longint sa;
        t = 1'b0;
        r = '0;
        case (o)
            4'd0: begin sa = longint'($signed(a)) + longint'($signed(b));
                  r = a + b; t = (sa > 64'sd2147483647) || (sa < -64'sd2147483648); end
            4'd1: r = a + b;
            4'd2: begin sa = longint'($signed(a)) - longint'($signed(b));
                  r = a - b; t = (sa > 64'sd2147483647) || (sa < -64'sd2147483648); end
            4'd3: r = a - b;
            4'd4: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd5: r = (a < b) ? 32'd1 : 32'd0;
            4'd6: r = b << s;
            4'd7: r = b >> s;
            4'd8: r = $signed(b) >>> s;
            4'd9: r = b << a[4:0];
            4'd10: r = b >> a[4:0];
            4'd11: r = $signed(b) >>> a[4:0];
            4'd12: r = a & b;
            4'd13: r = a | b;
            4'd14: r = ~(a | b);
            default: r = a ^ b;
        endcase
    endfunction

    // Driver: present one operation and queue its expected outcome.
    task automatic drive(input logic [3:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] s, input string tag);
        logic [31:0] r;
        logic t;
        @(negedge clk);
        op = o; opa = a; opb = b; shamt = s; in_valid = 1'b1;
        model(o, a, b, s, r, t);
        q_res.push_back(r);
        q_trp.push_back(t);
        q_tag.push_back(tag);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every valid result against the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid && q_res.size() > 0) begin
            logic [31:0] er;
            logic et;
            string tg;
            er = q_res.pop_front();
            et = q_trp.pop_front();
            tg = q_tag.pop_front();
            chk(result == er, {tg, " result"}, result, er);
            chk(ovf_trap == et, {tg, " trap"}, {31'd0, ovf_trap}, {31'd0, et});
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0 && ovf_trap == 1'b0 && result == 32'd0,
            "R11 reset", {result[29:0], res_valid, ovf_trap}, 32'd0);
        rst_n = 1'b1;

        // R1: wrapped add and subtract.
        drive(4'd1, 32'hFFFF_FFFF, 32'd2, 5'd0, "R1 addu wrap");
        drive(4'd3, 32'd5, 32'd6, 5'd0, "R1 subu 5-6");
        drive(4'd0, 32'd100, 32'hFFFF_FFF6, 5'd0, "R1 add mixed");
        // R2: signed add overflow.
        drive(4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0, "R2 add pos ovf");
        drive(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, "R2 add neg ovf");
        drive(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 5'd0, "R2 add neg ok");
        // R3: signed subtract overflow.
        drive(4'd2, 32'h8000_0000, 32'd1, 5'd0, "R3 sub neg-pos ovf");
        drive(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R3 sub pos-neg ovf");
        drive(4'd2, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, "R3 sub same sign");
        // R4: unsigned forms and others never trap.
        drive(4'd1, 32'h7FFF_FFFF, 32'd1, 5'd0, "R4 addu no trap");
        drive(4'd3, 32'h8000_0000, 32'd1, 5'd0, "R4 subu no trap");
        drive(4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R4 slt no trap");
        // R5 / R6: compares.
        drive(4'd4, 32'hFFFF_FFFF, 32'd1, 5'd0, "R5 slt -1<1");
        drive(4'd4, 32'd3, 32'd3, 5'd0, "R5 slt equal");
        drive(4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R5 slt max vs min");
        drive(4'd5, 32'hFFFF_FFFF, 32'd1, 5'd0, "R6 sltu big");
        drive(4'd5, 32'd1, 32'hFFFF_FFFF, 5'd0, "R6 sltu small");
        // R7 / R8: constant shifts.
        drive(4'd6, 32'd0, 32'h8000_00AD, 5'd1, "R7 sll 1");
        drive(4'd7, 32'd0, 32'h8000_00AD, 5'd31, "R7 srl 31");
        drive(4'd7, 32'd0, 32'hDEAD_BEEF, 5'd0, "R7 srl 0");
        drive(4'd8, 32'd0, 32'h8000_00AD, 5'd4, "R8 sra neg");
        drive(4'd8, 32'd0, 32'h4000_0000, 5'd30, "R8 sra pos");
        drive(4'd8, 32'd0, 32'hA800_0000, 5'd27, "R8 sra field");
        // R9: variable shifts use opa[4:0] only.
        drive(4'd9, 32'hFFFF_FFE3, 32'h0000_0001, 5'd7, "R9 sllv 3");
        drive(4'd10, 32'h0000_0020, 32'hF000_0000, 5'd9, "R9 srlv 0");
        drive(4'd11, 32'h1234_567F, 32'h8000_0000, 5'd0, "R9 srav 31");
        // R10: bitwise.
        drive(4'd12, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R10 and");
        drive(4'd13, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R10 or");
        drive(4'd14, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R10 nor");
        drive(4'd15, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, "R10 xor");

        // R11: overflowing add without valid raises nothing.
        @(negedge clk);
        op = 4'd0; opa = 32'h7FFF_FFFF; opb = 32'd1; in_valid = 1'b0;
        @(negedge clk);
        chk(res_valid == 1'b0 && ovf_trap == 1'b0, "R11 no valid no trap",
            {30'd0, res_valid, ovf_trap}, 32'd0);
        chk(q_res.size() == 0, "R11 queue drained", q_res.size(), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule